// File: doc/BRIEF.md
# Half-Precision Transfer and Conversion Unit

This unit is the small floating-point data path that lets a vector engine work with 16-bit IEEE binary16 values. It does not keep a register file. Each valid request carries an operation code, a rounding selection, an integer source word, a floating-point source word and a 16-bit load datum. One cycle later the unit returns the value to be written back: an FLEN-wide floating-point word, an XLEN-wide integer word, or a 16-bit store datum. It also returns the IEEE exception flags and an illegal-request indication.

A half value written into the FP register file is NaN-boxed: every bit above bit 15 is set to one. A half value moved to the integer side is sign-extended. The two converters work between binary16 and binary32. Widening is always exact. Narrowing rounds with the selected or the dynamic rounding mode. Any FP source whose boxing is broken is read as the canonical NaN.

Top module: `half_xfer_unit`

## Requirements
- R1: Operation 3'b000 (load) returns `resFp` = `loadData` in bits 15:0 with all bits above 15 set to one.
- R2: Operation 3'b001 (store) returns `resStore` = `fpSrc[15:0]`; the upper bits of `fpSrc` have no effect and `resFp` stays zero.
- R3: Operation 3'b010 (FP-to-integer move) returns `resInt` = `fpSrc[15:0]` sign-extended from bit 15 to XLEN.
- R4: Operation 3'b011 (integer-to-FP move) returns `resFp` = `intSrc[15:0]` NaN-boxed; the upper bits of `intSrc` have no effect.
- R5: Operation 3'b100 widens half to single exactly, for normals, signed zeros, infinities and subnormals (which become normalised singles). The result is boxed into FLEN with ones above bit 31.
- R6: In widening, a signalling NaN (quiet bit 9 clear) gives 32'h7FC00000 and sets the invalid flag. A quiet NaN gives the same value with no flag. A half source whose bits above 15 are not all ones is read as a quiet NaN.
- R7: Operation 3'b101 narrows single to half. Rounding encodings are 000 nearest-even, 001 toward zero, 010 down, 011 up and 100 nearest-max-magnitude; 111 takes the mode from `dynRm`. The inexact flag is set whenever bits are lost.
- R8: A narrowed result beyond the half range sets overflow and inexact. It returns infinity or 0x7BFF with the operand's sign: toward zero always gives 0x7BFF, down gives 0x7BFF for positive values, and up gives 0x7BFF for negative values.
- R9: Values below the half normal range narrow to correctly rounded subnormals. Underflow is set when the source exponent is below the half normal range (tininess before rounding) and the result is inexact.
- R10: A NaN narrowing source gives 16'h7E00 boxed, with invalid set only for a signalling NaN. A single source whose bits above 31 are not all ones also gives 16'h7E00, with no flag.
- R11: For conversions, an effective rounding mode of 101, 110 or 111 is illegal, and so are operation codes 110 and 111. An illegal request sets `resIllegal` and returns zero results and zero flags.
- R12: Results appear one clock after `inValid`, and `outValid` mirrors `inValid` delayed by one cycle. After reset every output is zero. The flag bits are {invalid, divide-by-zero, overflow, underflow, inexact} from bit 4 down to bit 0, and output words that an operation does not produce are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| inValid | input | 1 | Request valid this cycle |
| opSel | input | 3 | Operation code |
| rmSel | input | 3 | Rounding mode, 111 = dynamic |
| dynRm | input | 3 | Dynamic rounding mode |
| intSrc | input | XLEN | Integer source word |
| fpSrc | input | FLEN | Floating-point source word |
| loadData | input | 16 | Datum from memory for a load |
| outValid | output | 1 | Result valid |
| resFp | output | FLEN | Floating-point result |
| resInt | output | XLEN | Integer result |
| resStore | output | 16 | Store datum |
| resFlags | output | 5 | IEEE exception flags |
| resIllegal | output | 1 | Request was illegal |

## Verification
A wrong internal state would show at the ports on the cycle after the offending request, because the unit holds no state beyond one output register. A bad decode would produce a wrong operation's words or a missing illegal bit. A rounding or normalisation slip would change the returned bits or the flag set for that single request. The bench therefore compares every output word and flag on the cycle after each request, using directed halfway, overflow, subnormal and NaN operands together with seeded random traffic.

// File: rtl/half_xfer_pkg.sv
package half_xfer_pkg;
  localparam logic [2:0] OP_LOAD   = 3'b000;
  localparam logic [2:0] OP_STORE  = 3'b001;
  localparam logic [2:0] OP_MVXH   = 3'b010;
  localparam logic [2:0] OP_MVHX   = 3'b011;
  localparam logic [2:0] OP_WIDEN  = 3'b100;
  localparam logic [2:0] OP_NARROW = 3'b101;

  localparam logic [2:0] RM_DYN = 3'b111;

  localparam logic [31:0] CANON_SINGLE = 32'h7FC0_0000;
  localparam logic [15:0] CANON_HALF   = 16'h7E00;
  localparam logic [15:0] HALF_INF     = 16'h7C00;
  localparam logic [15:0] HALF_MAXFIN  = 16'h7BFF;

  typedef struct packed {
    logic       doLoad;
    logic       doStore;
    logic       doMvXH;
    logic       doMvHX;
    logic       doWiden;
    logic       doNarrow;
    logic       illegal;
    logic [2:0] rmEff;
  } strobe_t;
endpackage

// File: rtl/half_xfer_ctrl.sv
module half_xfer_ctrl
  import half_xfer_pkg::*;
(
  input  logic [2:0] opSel,
  input  logic [2:0] rmSel,
  input  logic [2:0] dynRm,
  output strobe_t    stb
);
  logic [2:0] rmEff;
  logic       rmBad;

  assign rmEff = (rmSel == RM_DYN) ? dynRm : rmSel;
  assign rmBad = (rmEff == 3'b101) || (rmEff == 3'b110) || (rmEff == 3'b111);

  always_comb begin
    stb       = '0;
    stb.rmEff = rmEff;
    case (opSel)
      OP_LOAD:   stb.doLoad  = 1'b1;
      OP_STORE:  stb.doStore = 1'b1;
      OP_MVXH:   stb.doMvXH  = 1'b1;
      OP_MVHX:   stb.doMvHX  = 1'b1;
      OP_WIDEN: begin
        stb.illegal = rmBad;
        stb.doWiden = !rmBad;
      end
      OP_NARROW: begin
        stb.illegal  = rmBad;
        stb.doNarrow = !rmBad;
      end
      default:   stb.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/half_widen.sv
module half_widen (
  input  logic [15:0] halfIn,
  output logic [31:0] singleOut,
  output logic        invalidOut
);
  logic       sgn;
  logic [4:0] expIn;
  logic [9:0] manIn;
  logic [3:0] lead;
  logic [10:0] normSh;

  assign sgn   = halfIn[15];
  assign expIn = halfIn[14:10];
  assign manIn = halfIn[9:0];

  always_comb begin
    lead = 4'd0;
    for (int i = 0; i < 10; i++) begin
      if (manIn[i]) lead = i[3:0];
    end
  end

  assign normSh = {1'b0, manIn} << (4'd10 - lead);

  always_comb begin
    invalidOut = 1'b0;
    if (expIn == 5'h1F) begin
      if (manIn == 10'd0) begin
        singleOut = {sgn, 8'hFF, 23'd0};
      end else begin
        singleOut  = 32'h7FC0_0000;
        invalidOut = !manIn[9];
      end
    end else if (expIn == 5'd0) begin
      if (manIn == 10'd0) singleOut = {sgn, 31'd0};
      else singleOut = {sgn, 8'd103 + {4'd0, lead}, normSh[9:0], 13'd0};
    end else begin
      singleOut = {sgn, {3'd0, expIn} + 8'd112, manIn, 13'd0};
    end
  end
endmodule

// File: rtl/half_narrow.sv
module half_narrow
  import half_xfer_pkg::*;
(
  input  logic [31:0] srcWord,
  input  logic        srcBoxed,
  input  logic [2:0]  rndMode,
  output logic [15:0] halfOut,
  output logic [4:0]  flagsOut
);
  logic        sgn;
  logic [7:0]  expIn;
  logic [22:0] manIn;
  logic [7:0]  expEff;
  logic        isTiny;
  logic [7:0]  shRaw;
  logic [5:0]  shAmt;
  logic [63:0] ext;
  logic [10:0] keep;
  logic        guardB, stickyB, inexact, roundUp;
  logic [11:0] rounded;
  logic [17:0] normMag;
  logic        ovf;
  logic        unusedExtHi;

  assign sgn    = srcWord[31];
  assign expIn  = srcWord[30:23];
  assign manIn  = srcWord[22:0];
  assign expEff = (expIn == 8'd0) ? 8'd1 : expIn;
  assign isTiny = expEff < 8'd113;
  assign shRaw  = 8'd126 - expEff;
  assign shAmt  = !isTiny ? 6'd13 : ((shRaw > 8'd40) ? 6'd40 : shRaw[5:0]);
  assign ext    = {(expIn != 8'd0), manIn, 40'd0} >> shAmt;
  assign keep   = ext[50:40];
  assign guardB = ext[39];
  assign stickyB = |ext[38:0];
  assign inexact = guardB | stickyB;
  assign unusedExtHi = |ext[63:51];

  always_comb begin
    case (rndMode)
      3'b000:  roundUp = guardB & (stickyB | keep[0]);
      3'b010:  roundUp = sgn & inexact;
      3'b011:  roundUp = !sgn & inexact;
      3'b100:  roundUp = guardB;
      default: roundUp = 1'b0;
    endcase
  end

  assign rounded = {1'b0, keep} + {11'd0, roundUp};
  assign normMag = (({10'd0, expIn} - 18'd113) << 10) + {6'd0, rounded};
  assign ovf     = !isTiny && (normMag >= 18'h07C00);

  always_comb begin
    flagsOut = 5'd0;
    if (!srcBoxed) begin
      halfOut = CANON_HALF;
    end else if (expIn == 8'hFF) begin
      if (manIn == 23'd0) begin
        halfOut = {sgn, HALF_INF[14:0]};
      end else begin
        halfOut     = CANON_HALF;
        flagsOut[4] = !manIn[22];
      end
    end else if (expIn == 8'd0 && manIn == 23'd0) begin
      halfOut = {sgn, 15'd0};
    end else if (ovf) begin
      flagsOut = 5'b00101;
      case (rndMode)
        3'b001:  halfOut = {sgn, HALF_MAXFIN[14:0]};
        3'b010:  halfOut = {sgn, sgn ? HALF_INF[14:0] : HALF_MAXFIN[14:0]};
        3'b011:  halfOut = {sgn, sgn ? HALF_MAXFIN[14:0] : HALF_INF[14:0]};
        default: halfOut = {sgn, HALF_INF[14:0]};
      endcase
    end else begin
      flagsOut[0] = inexact;
      flagsOut[1] = isTiny & inexact;
      if (isTiny) halfOut = {sgn, 4'd0, rounded[10:0]};
      else halfOut = {sgn, normMag[14:0]};
    end
  end
endmodule

// File: rtl/half_xfer_dp.sv
module half_xfer_dp
  import half_xfer_pkg::*;
#(
  parameter int FLEN = 64,
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inValid,
  input  strobe_t         stb,
  input  logic [15:0]     intLow,
  input  logic [FLEN-1:0] fpSrc,
  input  logic [15:0]     loadData,
  output logic            outValid,
  output logic [FLEN-1:0] resFp,
  output logic [XLEN-1:0] resInt,
  output logic [15:0]     resStore,
  output logic [4:0]      resFlags,
  output logic            resIllegal
);
  localparam int HBOX = FLEN - 16;
  localparam int XEXT = XLEN - 16;

  logic            halfBoxed, singleBoxed;
  logic [31:0]     widenOut;
  logic            widenNv;
  logic [FLEN-1:0] wideBoxed;
  logic [15:0]     narrowHalf;
  logic [4:0]      narrowFlags;
  logic [FLEN-1:0] nFp;
  logic [XLEN-1:0] nInt;
  logic [15:0]     nStore;
  logic [4:0]      nFlags;

  assign halfBoxed = &fpSrc[FLEN-1:16];

  generate
    if (FLEN > 32) begin : g_wide
      assign singleBoxed = &fpSrc[FLEN-1:32];
      assign wideBoxed   = {{(FLEN-32){1'b1}}, widenOut};
    end else begin : g_narrowreg
      assign singleBoxed = 1'b1;
      assign wideBoxed   = widenOut;
    end
  endgenerate

  half_widen u_widen (
    .halfIn    (halfBoxed ? fpSrc[15:0] : CANON_HALF),
    .singleOut (widenOut),
    .invalidOut(widenNv)
  );

  half_narrow u_narrow (
    .srcWord (fpSrc[31:0]),
    .srcBoxed(singleBoxed),
    .rndMode (stb.rmEff),
    .halfOut (narrowHalf),
    .flagsOut(narrowFlags)
  );

  always_comb begin
    nFp    = '0;
    nInt   = '0;
    nStore = '0;
    nFlags = '0;
    if (stb.doLoad)  nFp    = {{HBOX{1'b1}}, loadData};
    if (stb.doStore) nStore = fpSrc[15:0];
    if (stb.doMvXH)  nInt   = {{XEXT{fpSrc[15]}}, fpSrc[15:0]};
    if (stb.doMvHX)  nFp    = {{HBOX{1'b1}}, intLow};
    if (stb.doWiden) begin
      nFp    = wideBoxed;
      nFlags = {widenNv, 4'd0};
    end
    if (stb.doNarrow) begin
      nFp    = {{HBOX{1'b1}}, narrowHalf};
      nFlags = narrowFlags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      resFp      <= '0;
      resInt     <= '0;
      resStore   <= '0;
      resFlags   <= '0;
      resIllegal <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        resFp      <= nFp;
        resInt     <= nInt;
        resStore   <= nStore;
        resFlags   <= nFlags;
        resIllegal <= stb.illegal;
      end
    end
  end

  p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  p_valid_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  p_load_box_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && stb.doLoad) |=>
      (resFp[FLEN-1:16] == {HBOX{1'b1}}) && (resFp[15:0] == $past(loadData)));
  p_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && stb.doMvXH) |=> (resInt[XLEN-1:16] == {XEXT{$past(fpSrc[15])}}));
  p_ovf_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && resFlags[2]) |-> resFlags[0]);
  p_uf_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && resFlags[1]) |-> resFlags[0]);
  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && resIllegal) |-> (resFlags == 5'd0 && resFp == '0));
endmodule

// File: rtl/half_xfer_unit.sv
module half_xfer_unit
  import half_xfer_pkg::*;
#(
  parameter int FLEN = 64,
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inValid,
  input  logic [2:0]      opSel,
  input  logic [2:0]      rmSel,
  input  logic [2:0]      dynRm,
  input  logic [XLEN-1:0] intSrc,
  input  logic [FLEN-1:0] fpSrc,
  input  logic [15:0]     loadData,
  output logic            outValid,
  output logic [FLEN-1:0] resFp,
  output logic [XLEN-1:0] resInt,
  output logic [15:0]     resStore,
  output logic [4:0]      resFlags,
  output logic            resIllegal
);
  strobe_t stb;
  logic    unusedIntHi;

  assign unusedIntHi = ^intSrc[XLEN-1:16];

  half_xfer_ctrl u_ctrl (
    .opSel(opSel),
    .rmSel(rmSel),
    .dynRm(dynRm),
    .stb  (stb)
  );

  half_xfer_dp #(.FLEN(FLEN), .XLEN(XLEN)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .stb       (stb),
    .intLow    (intSrc[15:0]),
    .fpSrc     (fpSrc),
    .loadData  (loadData),
    .outValid  (outValid),
    .resFp     (resFp),
    .resInt    (resInt),
    .resStore  (resStore),
    .resFlags  (resFlags),
    .resIllegal(resIllegal)
  );
endmodule

// File: tb/test_half_xfer_unit.sv
module test_half_xfer_unit;
  localparam int FL = 64;
  localparam int XL = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] opSel = '0, rmSel = '0, dynRm = '0;
  logic [XL-1:0] intSrc = '0;
  logic [FL-1:0] fpSrc = '0;
  logic [15:0] loadData = '0;
  logic outValid;
  logic [FL-1:0] resFp;
  logic [XL-1:0] resInt;
  logic [15:0] resStore;
  logic [4:0] resFlags;
  logic resIllegal;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  half_xfer_unit #(.FLEN(FL), .XLEN(XL)) i_half_xfer_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opSel(opSel), .rmSel(rmSel),
    .dynRm(dynRm), .intSrc(intSrc), .fpSrc(fpSrc), .loadData(loadData),
    .outValid(outValid), .resFp(resFp), .resInt(resInt), .resStore(resStore),
    .resFlags(resFlags), .resIllegal(resIllegal));

  function automatic logic [31:0] refH2S(input logic [15:0] h, output logic nv);
    logic s; logic [4:0] e; logic [9:0] m; int ee; logic [10:0] sg;
    nv = 0; s = h[15]; e = h[14:10]; m = h[9:0];
    if (e == 5'h1F) begin
      if (m == 0) return {s, 8'hFF, 23'd0};
      nv = !m[9];
      return 32'h7FC00000;
    end
    if (e == 0 && m == 0) return {s, 31'd0};
    if (e == 0) begin
      ee = -14; sg = {1'b0, m};
      while (!sg[10]) begin sg = sg << 1; ee--; end
    end else begin
      ee = int'(e) - 15; sg = {1'b1, m};
    end
    return {s, 8'(ee + 127), sg[9:0], 13'd0};
  endfunction

  function automatic logic [15:0] refS2H(input logic [31:0] x, input logic [2:0] rm,
                                         output logic [4:0] fl);
    logic s; logic [7:0] e; logic [22:0] m; logic [24:0] sig;
    int ex, lsbw, qw; logic g, st, inc, tiny;
    fl = 0; s = x[31]; e = x[30:23]; m = x[22:0];
    if (e == 8'hFF) begin
      if (m == 0) return {s, 15'h7C00};
      fl[4] = !m[22];
      return 16'h7E00;
    end
    if (e == 0 && m == 0) return {s, 15'd0};
    sig = {1'b0, (e != 0), m};
    ex = (e != 0) ? int'(e) - 127 : -126;
    tiny = (ex < -14);
    lsbw = ex - 23;
    qw = tiny ? -24 : ex - 10;
    g = 0; st = 0;
    while (lsbw < qw) begin st = st | g; g = sig[0]; sig = sig >> 1; lsbw++; end
    case (rm)
      3'b000: inc = g & (st | sig[0]);
      3'b010: inc = s & (g | st);
      3'b011: inc = !s & (g | st);
      3'b100: inc = g;
      default: inc = 0;
    endcase
    sig = sig + 25'(inc);
    fl[0] = g | st;
    fl[1] = tiny & (g | st);
    if (tiny) return {s, 4'd0, sig[10:0]};
    if (sig == 25'd2048) begin sig = 25'd1024; ex++; end
    if (ex > 15) begin
      fl = 5'b00101;
      if (rm == 3'b001 || (rm == 3'b010 && !s) || (rm == 3'b011 && s)) return {s, 15'h7BFF};
      return {s, 15'h7C00};
    end
    return {s, 5'(ex + 15), sig[9:0]};
  endfunction

  task automatic runOp(input logic [2:0] op, input logic [2:0] rm, input logic [2:0] dyn,
                       input logic [63:0] iv, input logic [63:0] fv, input logic [15:0] ld,
                       input string tag);
    logic [FL-1:0] eFp; logic [XL-1:0] eInt; logic [15:0] eSt; logic [4:0] eFl; logic eIll;
    logic [2:0] rmE; logic nv; logic [31:0] sw; logic [15:0] hw;
    opSel = op; rmSel = rm; dynRm = dyn; intSrc = iv; fpSrc = fv; loadData = ld; inValid = 1;
    eFp = 0; eInt = 0; eSt = 0; eFl = 0; eIll = 0;
    rmE = (rm == 3'b111) ? dyn : rm;
    if (op > 3'd5 || (op >= 3'd4 && rmE >= 3'd5)) eIll = 1;
    else case (op)
      3'd0: eFp = {48'hFFFF_FFFF_FFFF, ld};
      3'd1: eSt = fv[15:0];
      3'd2: eInt = {{48{fv[15]}}, fv[15:0]};
      3'd3: eFp = {48'hFFFF_FFFF_FFFF, iv[15:0]};
      3'd4: begin
        if (fv[63:16] != 48'hFFFF_FFFF_FFFF) sw = 32'h7FC00000;
        else begin sw = refH2S(fv[15:0], nv); eFl[4] = nv; end
        eFp = {32'hFFFF_FFFF, sw};
      end
      default: begin
        if (fv[63:32] != 32'hFFFF_FFFF) hw = 16'h7E00;
        else hw = refS2H(fv[31:0], rmE, eFl);
        eFp = {48'hFFFF_FFFF_FFFF, hw};
      end
    endcase
    @(negedge clk);
    nChecks++;
    if ({outValid, resFp, resInt, resStore, resFlags, resIllegal} !==
        {1'b1, eFp, eInt, eSt, eFl, eIll}) begin
      nFails++;
      $display("FAIL %s op=%0d rm=%0d fp=%h: got fp=%h int=%h st=%h fl=%b ill=%b v=%b exp fp=%h int=%h st=%h fl=%b ill=%b",
               tag, op, rm, fv, resFp, resInt, resStore, resFlags, resIllegal, outValid,
               eFp, eInt, eSt, eFl, eIll);
    end
  endtask

  function automatic string tagFor(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5/R6";
      3'd5: return "R7";
      default: return "R11";
    endcase
  endfunction

  localparam logic [63:0] SB = 64'hFFFF_FFFF_0000_0000;
  localparam logic [63:0] HB = 64'hFFFF_FFFF_FFFF_0000;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    nChecks++;
    if ({outValid, resFp, resInt, resStore, resFlags, resIllegal} !== '0) begin
      nFails++;
      $display("FAIL R12 reset state: got v=%b fp=%h int=%h exp all zero", outValid, resFp, resInt);
    end
    rst_n = 1;
    @(negedge clk);

    runOp(3'd0, 0, 0, 0, 0, 16'h3C00, "R1");
    runOp(3'd1, 0, 0, 0, 64'h1234_5678_9ABC_DEF0, 0, "R2");
    runOp(3'd1, 0, 0, 0, 64'h0000_0000_0000_DEF0, 0, "R2");
    runOp(3'd2, 0, 0, 0, 64'h0000_0000_0000_8001, 0, "R3");
    runOp(3'd2, 0, 0, 0, HB | 64'h7FFF, 0, "R3");
    runOp(3'd3, 0, 0, 64'hABCD_0000_0000_1234, 0, 0, "R4");
    runOp(3'd4, 0, 0, 0, HB | 64'h3C00, 0, "R5");
    runOp(3'd4, 0, 0, 0, HB | 64'h0001, 0, "R5");
    runOp(3'd4, 0, 0, 0, HB | 64'h03FF, 0, "R5");
    runOp(3'd4, 0, 0, 0, HB | 64'hFC00, 0, "R5");
    runOp(3'd4, 0, 0, 0, HB | 64'h8000, 0, "R5");
    runOp(3'd4, 0, 0, 0, HB | 64'h7C01, 0, "R6");
    runOp(3'd4, 0, 0, 0, HB | 64'h7E01, 0, "R6");
    runOp(3'd4, 0, 0, 0, 64'h0000_0000_0000_3C00, 0, "R6");
    for (int r = 0; r < 5; r++) begin
      runOp(3'd5, 3'(r), 0, 0, SB | 64'h3F80_1000, 0, "R7");
      runOp(3'd5, 3'(r), 0, 0, SB | 64'hBF80_3000, 0, "R7");
      runOp(3'd5, 3'(r), 0, 0, SB | 64'h477F_F000, 0, "R8");
      runOp(3'd5, 3'(r), 0, 0, SB | 64'hD01502F9, 0, "R8");
      runOp(3'd5, 3'(r), 0, 0, SB | 64'h33C0_0000, 0, "R9");
      runOp(3'd5, 3'(r), 0, 0, SB | 64'h0000_0001, 0, "R9");
    end
    runOp(3'd5, 3'b111, 3'b011, 0, SB | 64'h3F80_1000, 0, "R7");
    runOp(3'd5, 0, 0, 0, SB | 64'h3880_0000, 0, "R9");
    runOp(3'd5, 0, 0, 0, SB | 64'h387F_F000, 0, "R9");
    runOp(3'd5, 0, 0, 0, SB | 64'h3380_0000, 0, "R9");
    runOp(3'd5, 0, 0, 0, SB | 64'h7F80_0001, 0, "R10");
    runOp(3'd5, 0, 0, 0, SB | 64'hFFC0_0000, 0, "R10");
    runOp(3'd5, 0, 0, 0, 64'h0000_0000_3F80_0000, 0, "R10");
    runOp(3'd5, 3'b101, 0, 0, SB | 64'h3F80_0000, 0, "R11");
    runOp(3'd5, 3'b110, 0, 0, SB | 64'h3F80_0000, 0, "R11");
    runOp(3'd4, 3'b111, 3'b111, 0, HB | 64'h3C00, 0, "R11");
    runOp(3'd6, 0, 0, 0, HB | 64'h3C00, 16'h1111, "R11");
    runOp(3'd7, 0, 0, 0, HB | 64'h3C00, 16'h1111, "R11");

    for (int k = 0; k < 800; k++) begin
      logic [3:0] pick; logic [2:0] op; logic [63:0] fv; logic [31:0] sv;
      pick = 4'($urandom % 16);
      op = (pick < 6) ? 3'(pick) : (pick < 11) ? 3'd5 : (pick < 14) ? 3'd4 : 3'(pick - 8);
      sv = $urandom;
      if ($urandom % 4 != 0) sv[30:23] = 8'(90 + $urandom % 50);
      if (op == 3'd4) fv = HB | 64'($urandom % 65536);
      else if (op == 3'd5) fv = {32'hFFFF_FFFF, sv};
      else fv = {$urandom, $urandom};
      if ($urandom % 16 == 0) fv[40] = 1'b0;
      runOp(op, 3'($urandom % 8), 3'($urandom % 8), {$urandom, $urandom}, fv,
            16'($urandom), tagFor(op));
    end

    inValid = 0;
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0) begin
      nFails++;
      $display("FAIL R12 valid drop: got %b exp 0", outValid);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule